// File: doc/BRIEF.md
# Trace Message Field Packer

The packer turns one trace message request into a packed, variable-length bit vector and a count of the valid bits in it. It builds three kinds of message. Two are data messages that carry synchronization: one for a data write and one for a data read. The third is an error report. In the data messages, the address field and the data value field are each trimmed to their significant bits, so the total length depends on the values being traced. The error report always has the same layout and length. Fields are placed starting at bit 0 and move toward higher bits, with the transfer code in the lowest bits.

A request is taken on a valid/ready handshake. The result is shown on a second valid/ready pair one cycle later. The block has a single output register. A request is accepted when that register is empty, or when the result it holds is being taken in the same cycle. When the consumer holds `msg_ready` low, the result stays unchanged and `req_ready` goes low. Back-pressure therefore reaches the producer without any request being lost. Deciding when a message must be sent, buffering messages, and shifting them out onto pins are all left to the blocks around the packer.

Top module: `trace_msg_packer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `msg_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. Its result appears with `msg_valid` = 1 after that edge. `req_ready` equals `!msg_valid || msg_ready`.
- R3: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_bits`, `msg_len` and `msg_illegal_code` keep their values on the next cycle.
- R4: `req_kind` selects the message kind. 2'b00 selects a data write, with transfer code 6'b001101. 2'b01 selects a data read, with transfer code 6'b001110. 2'b10 and 2'b11 select an error report, with transfer code 6'b001000. The transfer code occupies `msg_bits[5:0]`, with its least significant bit at bit 0.
- R5: An error report places the source field at `msg_bits[9:6]` and the error code at `msg_bits[14:10]`. Its `msg_len` is 15.
- R6: A data message places the source field at `msg_bits[9:6]` and the size field at `msg_bits[12:10]`. The address follows from bit 13 and takes A bits, where A is one more than the index of its highest set bit. The data value follows directly after it and takes D bits, found the same way. `msg_len` = 13 + A + D.
- R7: An address or data value of zero still takes exactly one bit, with the value 0, in a data message.
- R8: `msg_len` is between 15 and 109, and every bit of `msg_bits` at or above position `msg_len` is 0.
- R9: For an error report whose code is not 5'b00010, 5'b00111 or 5'b01000, `msg_illegal_code` is 1 and the code is still packed exactly as given. For legal codes and for data messages the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer can take a request |
| req_kind | input | 2 | Message kind selector |
| req_src | input | 4 | Source process identifier |
| req_size | input | 3 | Data size code (data messages) |
| req_addr | input | 32 | Full data address (data messages) |
| req_data | input | 64 | Data value (data messages) |
| req_err | input | 5 | Error code (error reports) |
| msg_valid | output | 1 | Packed result present |
| msg_ready | input | 1 | Consumer takes the result |
| msg_bits | output | 109 | Packed message, bit 0 first |
| msg_len | output | 7 | Number of valid bits in `msg_bits` |
| msg_illegal_code | output | 1 | Error code is outside the legal set |

## Verification
A request accepted at a rising edge produces its packed result, its length and its flag after that same edge. The bench therefore drives each request at a falling edge and checks the outputs at the next falling edge, half a cycle after acceptance. The bench holds `msg_ready` low for one more cycle to confirm that the result does not change and that `req_ready` has dropped. It then raises `msg_ready` and checks, one falling edge later, that the register is empty again. For the back-to-back and mid-message reset cases, each check is made at the first falling edge after the edge that should cause the change.

// File: rtl/tmp_pkg.sv
package tmp_pkg;
  localparam int TCODE_W = 6;
  localparam int SRC_W   = 4;
  localparam int SIZE_W  = 3;
  localparam int ERR_W   = 5;
  localparam int HDR_W   = TCODE_W + SRC_W + SIZE_W;
  localparam int ERRMSG_W = TCODE_W + SRC_W + ERR_W;

  localparam logic [TCODE_W-1:0] TC_DWRITE = 6'b001101;
  localparam logic [TCODE_W-1:0] TC_DREAD  = 6'b001110;
  localparam logic [TCODE_W-1:0] TC_ERROR  = 6'b001000;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'b00,
    KIND_READ  = 2'b01,
    KIND_ERR   = 2'b10,
    KIND_ERR2  = 2'b11
  } msg_kind_e;
endpackage

// File: rtl/tmp_sig_width.sv
// Number of significant bits in a value: highest set bit index + 1, minimum 1.
module tmp_sig_width #(
  parameter int W  = 32,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [OW-1:0] width
);
  always_comb begin
    width = OW'(1);
    for (int i = 0; i < W; i++) begin
      if (val[i]) width = OW'(i + 1);
    end
  end
endmodule

// File: rtl/tmp_assembler.sv
// Combinational field placement and length computation.
module tmp_assembler
  import tmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MSG_W  = HDR_W + ADDR_W + DATA_W,
  parameter int LEN_W  = $clog2(MSG_W + 1),
  parameter int AW_W   = $clog2(ADDR_W + 1),
  parameter int DW_W   = $clog2(DATA_W + 1)
) (
  input  logic [1:0]        kind,
  input  logic [SRC_W-1:0]  src,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ERR_W-1:0]  err,
  input  logic [AW_W-1:0]   addr_w,
  input  logic [DW_W-1:0]   data_w,
  output logic [MSG_W-1:0]  bits,
  output logic [LEN_W-1:0]  len,
  output logic              illegal
);
  logic [TCODE_W-1:0] tcode;
  logic [LEN_W-1:0]   data_pos;
  logic               is_err;

  assign is_err   = kind[1];
  assign data_pos = LEN_W'(HDR_W) + LEN_W'(addr_w);

  always_comb begin
    unique case (kind)
      KIND_WRITE: tcode = TC_DWRITE;
      KIND_READ:  tcode = TC_DREAD;
      default:    tcode = TC_ERROR;
    endcase
  end

  always_comb begin
    if (is_err) begin
      bits = MSG_W'(tcode)
           | (MSG_W'(src) << TCODE_W)
           | (MSG_W'(err) << (TCODE_W + SRC_W));
      len  = LEN_W'(ERRMSG_W);
    end else begin
      bits = MSG_W'(tcode)
           | (MSG_W'(src)  << TCODE_W)
           | (MSG_W'(size) << (TCODE_W + SRC_W))
           | (MSG_W'(addr) << HDR_W)
           | (MSG_W'(data) << data_pos);
      len  = data_pos + LEN_W'(data_w);
    end
  end

  always_comb begin
    illegal = 1'b0;
    if (is_err) begin
      case (err)
        5'b00010, 5'b00111, 5'b01000: illegal = 1'b0;
        default:                      illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tmp_out_stage.sv
// Single output register with valid/ready on both sides.
module tmp_out_stage #(
  parameter int MSG_W = 109,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MSG_W-1:0] in_bits,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_illegal,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MSG_W-1:0] out_bits,
  output logic [LEN_W-1:0] out_len,
  output logic             out_illegal
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bits    <= '0;
      out_len     <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_bits    <= in_bits;
      out_len     <= in_len;
      out_illegal <= in_illegal;
    end
  end
endmodule

// File: rtl/trace_msg_packer.sv
module trace_msg_packer
  import tmp_pkg::*;
#(
  parameter int  ADDR_W = 32,
  parameter int  DATA_W = 64,
  localparam int MSG_W  = HDR_W + ADDR_W + DATA_W,
  localparam int LEN_W  = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ERR_W-1:0]  req_err,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [MSG_W-1:0]  msg_bits,
  output logic [LEN_W-1:0]  msg_len,
  output logic              msg_illegal_code
);
  localparam int AW_W = $clog2(ADDR_W + 1);
  localparam int DW_W = $clog2(DATA_W + 1);

  logic [AW_W-1:0]  addr_w;
  logic [DW_W-1:0]  data_w;
  logic [MSG_W-1:0] nxt_bits;
  logic [LEN_W-1:0] nxt_len;
  logic             nxt_illegal;

  tmp_sig_width #(.W(ADDR_W), .OW(AW_W)) u_addr_w (.val(req_addr), .width(addr_w));
  tmp_sig_width #(.W(DATA_W), .OW(DW_W)) u_data_w (.val(req_data), .width(data_w));

  tmp_assembler #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSG_W(MSG_W),
    .LEN_W(LEN_W), .AW_W(AW_W), .DW_W(DW_W)
  ) u_asm (
    .kind(req_kind), .src(req_src), .size(req_size), .addr(req_addr),
    .data(req_data), .err(req_err), .addr_w(addr_w), .data_w(data_w),
    .bits(nxt_bits), .len(nxt_len), .illegal(nxt_illegal)
  );

  tmp_out_stage #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_bits(nxt_bits), .in_len(nxt_len), .in_illegal(nxt_illegal),
    .out_valid(msg_valid), .out_ready(msg_ready),
    .out_bits(msg_bits), .out_len(msg_len), .out_illegal(msg_illegal_code)
  );
endmodule

// File: rtl/tmp_checker.sv
module tmp_checker #(
  parameter int MSG_W = 109,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [MSG_W-1:0] msg_bits,
  input logic [LEN_W-1:0] msg_len,
  input logic             msg_illegal_code
);
  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid || msg_ready) |-> req_ready); // R2
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> msg_valid); // R2
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_bits) && $stable(msg_len)
                                   && $stable(msg_illegal_code))); // R3
  AST_ERR_FIXED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_bits[5:0] == 6'b001000) |-> msg_len == LEN_W'(15)); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_len >= LEN_W'(15) && msg_len <= LEN_W'(MSG_W))); // R8
  AST_NO_BITS_ABOVE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_bits >> msg_len) == '0)); // R8
  AST_FLAG_ONLY_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_illegal_code) |-> msg_bits[5:0] == 6'b001000); // R9
endmodule

bind trace_msg_packer tmp_checker #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_bits(msg_bits),
  .msg_len(msg_len), .msg_illegal_code(msg_illegal_code)
);

// File: tb/sim_trace_msg_packer.sv
`timescale 1ns/1ps
module sim_trace_msg_packer;
  localparam int MSG_W = 109;
  localparam int VEC_W = 2 + 4 + 3 + 32 + 64 + 5 + 7 + 1;
  localparam int NVEC  = 8;

  // {kind, src, size, addr, data, err, exp_len, exp_illegal}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {2'b00, 4'h3, 3'd2, 32'h1000_0000, 64'h0000_0000_0000_00FF, 5'd0, 7'd50, 1'b0},
    {2'b01, 4'h9, 3'd0, 32'h0000_0000, 64'h0,                   5'd0, 7'd15, 1'b0},
    {2'b00, 4'hF, 3'd7, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 7'd109, 1'b0},
    {2'b10, 4'h1, 3'd0, 32'h0,         64'h0,                   5'b00010, 7'd15, 1'b0},
    {2'b10, 4'hA, 3'd5, 32'h1234,      64'h55,                  5'b00111, 7'd15, 1'b0},
    {2'b10, 4'h6, 3'd0, 32'h0,         64'h0,                   5'b01000, 7'd15, 1'b0},
    {2'b11, 4'hC, 3'd0, 32'h0,         64'h0,                   5'b11111, 7'd15, 1'b1},
    {2'b01, 4'h2, 3'd3, 32'h0000_0001, 64'h8000_0000_0000_0000, 5'd0, 7'd78, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_src = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic [4:0]  req_err = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [MSG_W-1:0] msg_bits;
  logic [6:0]  msg_len;
  logic        msg_illegal_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_msg_packer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_size(req_size),
    .req_addr(req_addr), .req_data(req_data), .req_err(req_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_bits(msg_bits),
    .msg_len(msg_len), .msg_illegal_code(msg_illegal_code)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference packing built bit by bit from the requirement text.
  function automatic logic [MSG_W-1:0] model(input logic [VEC_W-1:0] v);
    logic [1:0] k; logic [3:0] s; logic [2:0] z; logic [31:0] a; logic [63:0] d; logic [4:0] e;
    logic [MSG_W-1:0] r; int na; int nd; int p;
    {k, s, z, a, d, e} = v[VEC_W-1:8];
    r = '0;
    r[5:0] = (k == 2'b00) ? 6'b001101 : (k == 2'b01) ? 6'b001110 : 6'b001000;
    r[9:6] = s;
    if (k[1]) begin
      r[14:10] = e;
    end else begin
      na = 1; nd = 1;
      for (int i = 31; i >= 0; i--) if (a[i]) begin na = i + 1; break; end
      for (int i = 63; i >= 0; i--) if (d[i]) begin nd = i + 1; break; end
      r[12:10] = z;
      p = 13;
      for (int i = 0; i < na; i++) begin r[p] = a[i]; p++; end
      for (int i = 0; i < nd; i++) begin r[p] = d[i]; p++; end
    end
    return r;
  endfunction

  task automatic drive(input logic [VEC_W-1:0] v);
    {req_kind, req_src, req_size, req_addr, req_data, req_err} = v[VEC_W-1:8];
    req_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 msg_valid in reset", 128'(msg_valid), 128'(0));
    chk("R1 req_ready in reset", 128'(req_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 msg_valid after reset", 128'(msg_valid), 128'(0));
    chk("R1 req_ready after reset", 128'(req_ready), 128'(1));

    // Table walk: R4..R9 per entry, plus stall and drain (R2, R3).
    for (int n = 0; n < NVEC; n++) begin
      drive(VECS[n]);
      chk("R2 ready before accept", 128'(req_ready), 128'(1));
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 result valid", 128'(msg_valid), 128'(1));
      chk("R4 R5 R6 R7 packed bits", 128'(msg_bits), 128'(model(VECS[n])));
      chk("R6 R8 length", 128'(msg_len), 128'(VECS[n][7:1]));
      chk("R9 illegal flag", 128'(msg_illegal_code), 128'(VECS[n][0]));
      @(negedge clk);
      chk("R3 held valid", 128'(msg_valid), 128'(1));
      chk("R3 held bits", 128'(msg_bits), 128'(model(VECS[n])));
      chk("R2 ready low under stall", 128'(req_ready), 128'(0));
      msg_ready = 1'b1;
      @(negedge clk);
      chk("R2 drained", 128'(msg_valid), 128'(0));
      msg_ready = 1'b0;
    end

    // Blocked request is not taken while stalled (R2).
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[2]);
    @(negedge clk);
    chk("R2 stalled request not taken", 128'(msg_len), 128'(50));
    msg_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 pass-through accept", 128'(msg_len), 128'(109));
    chk("R2 pass-through valid", 128'(msg_valid), 128'(1));

    // Back-to-back with ready high (R2).
    drive(VECS[6]);
    @(negedge clk);
    drive(VECS[7]);
    chk("R9 back-to-back first", 128'(msg_illegal_code), 128'(1));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 back-to-back second", 128'(msg_len), 128'(78));
    @(negedge clk);
    chk("R2 empty after drain", 128'(msg_valid), 128'(0));

    // Reset while holding a result (R1).
    msg_ready = 1'b0;
    drive(VECS[4]);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears result", 128'(msg_valid), 128'(0));
    chk("R1 ready after mid reset", 128'(req_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule